// File: doc/BRIEF.md
# Boundary-Programmed Display Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, data enable, and the pixel coordinates inside the visible area. It also produces a strobe at the end of each line and a strobe when the visible part of a frame is over. Each axis is programmed with four cumulative positions, each held as a count minus one: the end of sync, the end of the back porch, the end of the visible area, and the last count of the period. Individual porch lengths are not used. Horizontal positions count pixel clocks. Vertical positions count whole lines.

The polarity of sync and data enable can be chosen separately for each signal. A further select sets the clock edge on which the outputs are launched: the rising edge, or the falling edge that follows it. No layer is composed here, so the block drives the background colour on every visible pixel and zero elsewhere. While the global enable is low the counters stay at zero and every output rests at its inactive level. Reset leaves the block disabled.

Top module: `disp_timing_gen`

## Requirements
- R1: With an axis count c, horizontal sync is active while c <= h_sync_end_i, so it lasts h_sync_end_i+1 clocks. Vertical sync is active while the line count <= v_sync_end_i.
- R2: Data enable is active only when the horizontal count is above h_bp_end_i and at or below h_act_end_i, and the line count is above v_bp_end_i and at or below v_act_end_i.
- R3: The horizontal count wraps to 0 after reaching h_total_i, so a line lasts h_total_i+1 clocks. The line count wraps after v_total_i, so a frame lasts v_total_i+1 lines.
- R4: While data enable is active, x_o equals the horizontal count minus h_bp_end_i minus 1 and y_o equals the line count minus v_bp_end_i minus 1. Both are 0 otherwise.
- R5: rgb_o equals bg_rgb_i (red in [23:16], green in [15:8], blue in [7:0]) while data enable is active, and 0 otherwise.
- R6: A polarity select of 1 makes the matching output (hsync_o, vsync_o, de_o) active high. A select of 0 makes it active low.
- R7: With pclk_rise_i=1 the outputs change just after the rising clock edge. With pclk_rise_i=0 the same values appear at the falling edge that follows.
- R8: After reset and while en_i is low, sync and data enable sit at their inactive levels, and x_o, y_o, rgb_o and both strobes are 0. When en_i is first sampled high, the outputs one clock later show position (0,0), and counting restarts from 0 each time the block is enabled.
- R9: line_end_o is high for exactly one clock per line, in the clock where the horizontal count equals h_total_i.
- R10: vblank_o is high for one clock per frame, in the last clock of line v_act_end_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable |
| h_sync_end_i | input | W | Horizontal sync width minus one |
| h_bp_end_i | input | W | Cumulative sync + back porch minus one (horizontal) |
| h_act_end_i | input | W | Cumulative sync + back porch + active width minus one |
| h_total_i | input | W | Cumulative total line length minus one |
| v_sync_end_i | input | W | Vertical sync height minus one |
| v_bp_end_i | input | W | Cumulative sync + back porch minus one (vertical) |
| v_act_end_i | input | W | Cumulative sync + back porch + active height minus one |
| v_total_i | input | W | Cumulative total frame length minus one |
| hs_pol_i | input | 1 | 1: hsync active high |
| vs_pol_i | input | 1 | 1: vsync active high |
| de_pol_i | input | 1 | 1: data enable active high |
| pclk_rise_i | input | 1 | 1: launch on rising edge, 0: on falling edge |
| bg_rgb_i | input | 24 | Background colour |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| x_o | output | W | Visible-area column |
| y_o | output | W | Visible-area row |
| rgb_o | output | 24 | Pixel colour |
| vblank_o | output | 1 | End-of-visible-frame strobe |
| line_end_o | output | 1 | End-of-line strobe |

## Verification
A horizontal count that is off by one shows at the ports within one line. The data enable window, x_o and the line strobe all shift against the programmed positions at the next visible pixel. A line counter that steps on the wrong condition, or wraps late, moves vsync, y_o and the vertical strobe, and this appears within one frame. The bench therefore compares every output in every clock over whole frames, for two configurations that differ in geometry, polarity and launch edge. Wrong polarity or wrong launch-edge handling is seen in the first clock after enable.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;
  typedef struct packed {
    logic in_sync;
    logic in_act;
    logic at_last;
    logic at_act_end;
  } axis_flags_t;
endpackage

// File: rtl/disp_axis_cnt.sv
module disp_axis_cnt
  import disp_timing_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         step_i,
  input  logic [W-1:0] sync_end_i,
  input  logic [W-1:0] bp_end_i,
  input  logic [W-1:0] act_end_i,
  input  logic [W-1:0] total_i,
  output logic [W-1:0] pos_o,
  output axis_flags_t  flags_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= flags_o.at_last ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    flags_o.in_sync    = cnt_q <= sync_end_i;
    flags_o.in_act     = (cnt_q > bp_end_i) && (cnt_q <= act_end_i);
    flags_o.at_last    = cnt_q >= total_i;
    flags_o.at_act_end = cnt_q == act_end_i;
    pos_o = flags_o.in_act ? cnt_q - bp_end_i - 1'b1 : '0;
  end

  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && step_i && (cnt_q == total_i) |=> cnt_q == '0);

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !step_i |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/disp_out_stage.sv
module disp_out_stage
  import disp_timing_pkg::*;
#(
  parameter int unsigned W  = 12,
  parameter int unsigned CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  axis_flags_t   h_i,
  input  axis_flags_t   v_i,
  input  logic [W-1:0]  x_i,
  input  logic [W-1:0]  y_i,
  input  logic [CW-1:0] bg_i,
  input  logic          hs_pol_i,
  input  logic          vs_pol_i,
  input  logic          de_pol_i,
  input  logic          rise_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [W-1:0]  x_o,
  output logic [W-1:0]  y_o,
  output logic [CW-1:0] rgb_o,
  output logic          vblank_o,
  output logic          line_end_o
);
  typedef struct packed {
    logic          hs;
    logic          vs;
    logic          de;
    logic [W-1:0]  x;
    logic [W-1:0]  y;
    logic [CW-1:0] rgb;
    logic          vb;
    logic          le;
  } px_t;

  px_t  nxt, rise_q, fall_q, sel;
  logic de_act;

  always_comb begin
    de_act = h_i.in_act & v_i.in_act;
    nxt.hs  = en_i ? (h_i.in_sync ~^ hs_pol_i) : ~hs_pol_i;
    nxt.vs  = en_i ? (v_i.in_sync ~^ vs_pol_i) : ~vs_pol_i;
    nxt.de  = en_i ? (de_act ~^ de_pol_i) : ~de_pol_i;
    nxt.x   = (en_i && de_act) ? x_i : '0;
    nxt.y   = (en_i && de_act) ? y_i : '0;
    nxt.rgb = (en_i && de_act) ? bg_i : '0;
    nxt.le  = en_i & h_i.at_last;
    nxt.vb  = en_i & h_i.at_last & v_i.at_act_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= nxt;
  end

  // falling-edge launch: retime the rising-edge word by half a cycle
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= rise_q;
  end

  assign sel        = rise_i ? rise_q : fall_q;
  assign hsync_o    = sel.hs;
  assign vsync_o    = sel.vs;
  assign de_o       = sel.de;
  assign x_o        = sel.x;
  assign y_o        = sel.y;
  assign rgb_o      = sel.rgb;
  assign vblank_o   = sel.vb;
  assign line_end_o = sel.le;

  // R8
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !rise_q.le && !rise_q.vb && rise_q.x == '0 && rise_q.y == '0 && rise_q.rgb == '0);

  // R10
  vb_in_le_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q.vb |-> rise_q.le);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import disp_timing_pkg::*;
#(
  parameter int unsigned W  = 12,
  parameter int unsigned CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [W-1:0]  h_sync_end_i,
  input  logic [W-1:0]  h_bp_end_i,
  input  logic [W-1:0]  h_act_end_i,
  input  logic [W-1:0]  h_total_i,
  input  logic [W-1:0]  v_sync_end_i,
  input  logic [W-1:0]  v_bp_end_i,
  input  logic [W-1:0]  v_act_end_i,
  input  logic [W-1:0]  v_total_i,
  input  logic          hs_pol_i,
  input  logic          vs_pol_i,
  input  logic          de_pol_i,
  input  logic          pclk_rise_i,
  input  logic [CW-1:0] bg_rgb_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [W-1:0]  x_o,
  output logic [W-1:0]  y_o,
  output logic [CW-1:0] rgb_o,
  output logic          vblank_o,
  output logic          line_end_o
);
  axis_flags_t  h_flags, v_flags;
  logic [W-1:0] h_pos, v_pos;

  disp_axis_cnt #(.W(W)) u_h (
    .clk_i, .rst_ni, .en_i,
    .step_i     (1'b1),
    .sync_end_i (h_sync_end_i),
    .bp_end_i   (h_bp_end_i),
    .act_end_i  (h_act_end_i),
    .total_i    (h_total_i),
    .pos_o      (h_pos),
    .flags_o    (h_flags)
  );

  // line counter advances once per completed line
  disp_axis_cnt #(.W(W)) u_v (
    .clk_i, .rst_ni, .en_i,
    .step_i     (h_flags.at_last),
    .sync_end_i (v_sync_end_i),
    .bp_end_i   (v_bp_end_i),
    .act_end_i  (v_act_end_i),
    .total_i    (v_total_i),
    .pos_o      (v_pos),
    .flags_o    (v_flags)
  );

  disp_out_stage #(.W(W), .CW(CW)) u_out (
    .clk_i, .rst_ni, .en_i,
    .h_i        (h_flags),
    .v_i        (v_flags),
    .x_i        (h_pos),
    .y_i        (v_pos),
    .bg_i       (bg_rgb_i),
    .hs_pol_i, .vs_pol_i, .de_pol_i,
    .rise_i     (pclk_rise_i),
    .hsync_o, .vsync_o, .de_o, .x_o, .y_o, .rgb_o, .vblank_o, .line_end_o
  );

  // R9
  line_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (h_total_i != '0) && h_flags.at_last |=> !h_flags.at_last);

  // R2
  de_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && h_flags.in_act |-> h_pos <= h_act_end_i - h_bp_end_i - 1'b1);
endmodule

// File: tb/disp_timing_gen_test.sv
module disp_timing_gen_test;
  localparam int W = 12;

  typedef struct {
    logic hs, vs, de;
    logic [W-1:0] x, y;
    logic [23:0] rgb;
    logic vb, le;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [W-1:0] hse, hbp, hae, ht, vse, vbp, vae, vt;
  logic hs_pol, vs_pol, de_pol, rise;
  logic [23:0] bg;
  logic hsync, vsync, de, vblank, line_end;
  logic [W-1:0] x, y;
  logic [23:0] rgb;

  int checks = 0, fails = 0;
  item_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  disp_timing_gen #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .h_sync_end_i(hse), .h_bp_end_i(hbp), .h_act_end_i(hae), .h_total_i(ht),
    .v_sync_end_i(vse), .v_bp_end_i(vbp), .v_act_end_i(vae), .v_total_i(vt),
    .hs_pol_i(hs_pol), .vs_pol_i(vs_pol), .de_pol_i(de_pol), .pclk_rise_i(rise),
    .bg_rgb_i(bg),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .x_o(x), .y_o(y), .rgb_o(rgb),
    .vblank_o(vblank), .line_end_o(line_end)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic item_t model(input int n);
    item_t it;
    int hc, vc;
    logic hact, vact, dea;
    hc = n % (int'(ht) + 1);
    vc = (n / (int'(ht) + 1)) % (int'(vt) + 1);
    hact = hc > int'(hbp) && hc <= int'(hae);
    vact = vc > int'(vbp) && vc <= int'(vae);
    dea = hact && vact;
    it.hs  = (hc <= int'(hse)) ? hs_pol : ~hs_pol;        // R1 R6
    it.vs  = (vc <= int'(vse)) ? vs_pol : ~vs_pol;
    it.de  = dea ? de_pol : ~de_pol;                        // R2
    it.x   = dea ? W'(hc - int'(hbp) - 1) : '0;             // R4
    it.y   = dea ? W'(vc - int'(vbp) - 1) : '0;
    it.rgb = dea ? bg : '0;                                 // R5
    it.le  = hc == int'(ht);                                // R9 R3
    it.vb  = it.le && vc == int'(vae);                      // R10
    return it;
  endfunction

  // monitor: sample 15 after each rising edge, after either launch edge
  initial begin
    forever begin
      @(posedge clk);
      #15;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        chk(hsync == e.hs, "R1/R6 hsync", hsync, e.hs);
        chk(vsync == e.vs, "R1/R6 vsync", vsync, e.vs);
        chk(de == e.de, "R2 de", de, e.de);
        chk(x == e.x && y == e.y, "R4 xy", {x, y}, {e.x, e.y});
        chk(rgb == e.rgb, "R5 rgb", rgb, e.rgb);
        chk(line_end == e.le, "R9 line_end", line_end, e.le);
        chk(vblank == e.vb, "R10 vblank", vblank, e.vb);
      end
    end
  end

  // driver: enable between sample point and next edge, push expected stream
  task automatic run(input int n);
    @(posedge clk); #17;
    en = 1'b1;
    for (int i = 0; i < n; i++) q.push_back(model(i));
    wait (q.size() == 0);
    @(posedge clk); #17;
    en = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    @(posedge clk); #15;
    chk(hsync == ~hs_pol && vsync == ~vs_pol && de == ~de_pol, {tag, " R8 idle levels"},
        {hsync, vsync, de}, {~hs_pol, ~vs_pol, ~de_pol});
    chk(x == 0 && y == 0 && rgb == 0 && !vblank && !line_end, {tag, " R8 idle data"},
        {x, y}, 0);
  endtask

  // R7: first clock after enable, hsync goes active at the selected edge
  task automatic launch_probe();
    @(posedge clk); #17;
    en = 1'b1;
    @(posedge clk); #5;
    chk(hsync == (rise ? hs_pol : ~hs_pol), "R7 before falling edge", hsync, rise ? hs_pol : ~hs_pol);
    #10;
    chk(hsync == hs_pol, "R7 after falling edge", hsync, hs_pol);
    #2;
    en = 1'b0;
    check_idle("post-probe");
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // config A: all active high, rising launch
    hse = 1; hbp = 3; hae = 7; ht = 9;
    vse = 0; vbp = 1; vae = 4; vt = 5;
    hs_pol = 1; vs_pol = 1; de_pol = 1; rise = 1; bg = 24'hA1B2C3;
    #35;
    chk(hsync == 0 && vsync == 0 && de == 0 && rgb == 0, "R8 reset state", {hsync, vsync, de}, 0);
    rst_n = 1'b1;
    check_idle("after reset");
    launch_probe();
    run(2 * 60);
    check_idle("after config A");

    // config B: mixed polarity, falling launch, new geometry; restart from 0
    hse = 2; hbp = 4; hae = 9; ht = 12;
    vse = 1; vbp = 2; vae = 5; vt = 6;
    hs_pol = 0; vs_pol = 1; de_pol = 0; rise = 0; bg = 24'h0F7E31;
    check_idle("config B");
    launch_probe();
    run(13 * 7 + 40);
    check_idle("after config B");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule